// File: doc/BRIEF.md
# Nibble-Addressed Serial Slave Port with Ready Handshake

This block is an eight-bit serial shift port for a small controller with a four-bit data bus. The serial clock comes from an external master. The CPU loads the byte to send as two four-bit halves. It starts the port by writing the trigger bit, then waits for a completion interrupt. After that it reads the received byte back through the same two halves.

An active-low ready line tells the external master when it may start clocking. Writing the trigger drives the line low. The line goes high again when the synchronized serial clock is first seen low. A CPU read or write of the upper half also drives it high.

A mode bit selects which serial clock edge moves the output bit and which edge samples the input. A build-time parameter selects whether the low end or the high end of the byte leaves first. The serial clock and the data input each pass through a two-flop synchronizer. The serial clock is then edge-detected in the system clock domain. Its period must be at least four system clocks.

Top module: `nib_serial_slave`

## Requirements
- R1: After reset, ser_rdy_n is 1, xfer_irq is 0, ser_dout is 0, cpu_rdata is 0, the shift register is 0, the running bit is 0 and the mode bit is 1.
- R2: Address 0 holds shift bits 3..0 and address 1 holds shift bits 7..4, with the register bit on the same cpu_wdata/cpu_rdata bit. At address 2, bit 0 writes the trigger and reads the running bit, and bit 1 is the mode bit, readable and writable. A read presents its data on cpu_rdata one clock after the cycle in which cpu_rd is high, and cpu_rdata holds that value until the next read.
- R3: With LSB_FIRST=1, bit 0 is shifted out first and the first received bit ends in bit 0. With LSB_FIRST=0, bit 7 leaves first and the first received bit ends in bit 7.
- R4: Writing 1 to the trigger bit while idle sets the running bit and drives ser_rdy_n low on the next clock edge.
- R5: While running, ser_rdy_n returns to 1 on the clock after the synchronized serial clock is low.
- R6: Any CPU read or write of address 1 returns ser_rdy_n to 1 on the next clock.
- R7: With mode 1, ser_dout updates on a falling serial clock edge and ser_din is sampled on a rising edge. With mode 0, the two edges swap roles.
- R8: The running bit stays 1 from the trigger until the eighth sampling edge, and clears on that edge.
- R9: xfer_irq is a single-cycle pulse, issued on the same edge that clears the running bit.
- R10: At trigger, ser_dout presents the first bit. After completion it keeps the last bit shifted out.
- R11: Serial clock edges that arrive while the port is idle change neither the shift register nor ser_dout.
- R12: While running, writes to addresses 0 and 1, writes to the mode bit, and further triggers are all ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 2 | Register select: 0 low half, 1 upper half, 2 control |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_wdata | input | 4 | Write data |
| cpu_rdata | output | 4 | Registered read data |
| ser_clk | input | 1 | Serial clock from the external master |
| ser_din | input | 1 | Serial data input |
| ser_dout | output | 1 | Serial data output |
| ser_rdy_n | output | 1 | Active-low ready to the master |
| xfer_irq | output | 1 | One-cycle completion pulse |

## Verification
Full transfers are run in both clock modes with different loaded and received bytes. Because the bytes differ, a swapped sampling edge, a reversed bit order or an off-by-one bit count shows up as a wrong captured output or a wrong received value. Serial clock toggling while idle, data and mode writes during a transfer, and a trigger followed by an upper-half read each isolate one path that releases or guards state. A behavioural model compared on every clock catches any cycle shift of ready, the interrupt or the output bit.

// File: rtl/nib_serial_pkg.sv
package nib_serial_pkg;
  typedef enum logic [1:0] {
    REG_LO   = 2'd0,
    REG_HI   = 2'd1,
    REG_CTL  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int CTL_RUN_BIT  = 0;
  localparam int CTL_MODE_BIT = 1;
endpackage

// File: rtl/nib_sync.sv
module nib_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nib_edge.sv
module nib_edge #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/nib_shift_core.sv
module nib_shift_core #(
  parameter int DATA_W    = 8,
  parameter int NIB_W     = 4,
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              load_lo,
  input  logic              load_hi,
  input  logic [NIB_W-1:0]  nib,
  input  logic              sample,
  input  logic              out_edge,
  input  logic              din,
  output logic [DATA_W-1:0] data_q,
  output logic              run,
  output logic              done,
  output logic              dout
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sr;
  logic [DATA_W-1:0] sr_next;
  logic              head;
  logic [CNT_W-1:0]  cnt;

  generate
    if (LSB_FIRST) begin : g_lsb
      assign head    = sr[0];
      assign sr_next = {din, sr[DATA_W-1:1]};
    end else begin : g_msb
      assign head    = sr[DATA_W-1];
      assign sr_next = {sr[DATA_W-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
      dout <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !run) begin
        run  <= 1'b1;
        cnt  <= '0;
        dout <= head;
      end else if (run) begin
        if (sample) begin
          sr <= sr_next;
          if (cnt == LAST) begin
            run  <= 1'b0;
            done <= 1'b1;
            cnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (out_edge) begin
          dout <= head;
        end
      end else begin
        if (load_lo) sr[NIB_W-1:0] <= nib;
        if (load_hi) sr[DATA_W-1 -: NIB_W] <= nib;
      end
    end
  end

  assign data_q = sr;
endmodule

// File: rtl/nib_serial_slave.sv
module nib_serial_slave
  import nib_serial_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NIB_W       = 4,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter bit LSB_FIRST   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [NIB_W-1:0]  cpu_wdata,
  output logic [NIB_W-1:0]  cpu_rdata,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic              ser_dout,
  output logic              ser_rdy_n,
  output logic              xfer_irq
);
  logic sclk_s, din_s, sclk_rise, sclk_fall;
  logic run_w, done_w, dout_w;
  logic mode_q, rdy_q;
  logic [NIB_W-1:0]  rdata_q;
  logic [DATA_W-1:0] data_w;
  logic sel_lo, sel_hi, sel_ctl, trig, hi_access;

  nib_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clk (
    .clk(clk), .rst(rst), .d(ser_clk), .q(sclk_s));
  nib_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
    .clk(clk), .rst(rst), .d(ser_din), .q(din_s));
  nib_edge #(.RST_VAL(1'b1)) u_edge (
    .clk(clk), .rst(rst), .lvl(sclk_s), .rise(sclk_rise), .fall(sclk_fall));

  assign sel_lo    = (cpu_addr == ADDR_W'(REG_LO));
  assign sel_hi    = (cpu_addr == ADDR_W'(REG_HI));
  assign sel_ctl   = (cpu_addr == ADDR_W'(REG_CTL));
  assign trig      = cpu_wr && sel_ctl && cpu_wdata[CTL_RUN_BIT];
  assign hi_access = (cpu_wr || cpu_rd) && sel_hi;

  nib_shift_core #(.DATA_W(DATA_W), .NIB_W(NIB_W), .LSB_FIRST(LSB_FIRST)) u_core (
    .clk(clk), .rst(rst),
    .start(trig),
    .load_lo(cpu_wr && sel_lo),
    .load_hi(cpu_wr && sel_hi),
    .nib(cpu_wdata),
    .sample(mode_q ? sclk_rise : sclk_fall),
    .out_edge(mode_q ? sclk_fall : sclk_rise),
    .din(din_s),
    .data_q(data_w),
    .run(run_w),
    .done(done_w),
    .dout(dout_w));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= 1'b1;
      rdy_q   <= 1'b1;
      rdata_q <= '0;
    end else begin
      if (cpu_wr && sel_ctl && !run_w) mode_q <= cpu_wdata[CTL_MODE_BIT];
      if (trig && !run_w)                        rdy_q <= 1'b0;
      else if ((run_w && !sclk_s) || hi_access)  rdy_q <= 1'b1;
      if (cpu_rd) begin
        unique case (cpu_addr)
          ADDR_W'(REG_LO):  rdata_q <= data_w[NIB_W-1:0];
          ADDR_W'(REG_HI):  rdata_q <= data_w[DATA_W-1 -: NIB_W];
          ADDR_W'(REG_CTL): begin
            rdata_q <= '0;
            rdata_q[CTL_RUN_BIT]  <= run_w;
            rdata_q[CTL_MODE_BIT] <= mode_q;
          end
          default:          rdata_q <= '0;
        endcase
      end
    end
  end

  assign cpu_rdata = rdata_q;
  assign ser_dout  = dout_w;
  assign ser_rdy_n = rdy_q;
  assign xfer_irq  = done_w;
endmodule

// File: rtl/nib_serial_checker.sv
module nib_serial_checker #(
  parameter int ADDR_W = 2,
  parameter int NIB_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic [NIB_W-1:0]  cpu_wdata,
  input logic              ser_dout,
  input logic              ser_rdy_n,
  input logic              xfer_irq,
  input logic              run
);
  logic trig_c;
  assign trig_c = cpu_wr && (cpu_addr == ADDR_W'(2)) && cpu_wdata[0];

  a_r4_trigger_arms: assert property (@(posedge clk) disable iff (rst)
    (trig_c && !run) |=> (!ser_rdy_n && run));
  a_r6_hi_access_releases: assert property (@(posedge clk) disable iff (rst)
    ((cpu_wr || cpu_rd) && cpu_addr == ADDR_W'(1)) |=> ser_rdy_n);
  a_r5_ready_low_needs_run: assert property (@(posedge clk) disable iff (rst)
    !ser_rdy_n |-> run);
  a_r9_irq_single: assert property (@(posedge clk) disable iff (rst)
    xfer_irq |=> !xfer_irq);
  a_r8_irq_at_run_end: assert property (@(posedge clk) disable iff (rst)
    xfer_irq |-> (!run && $past(run)));
  a_r11_idle_dout_stable: assert property (@(posedge clk) disable iff (rst)
    (!run && !trig_c) |=> $stable(ser_dout));
endmodule

bind nib_serial_slave nib_serial_checker #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .cpu_wdata(cpu_wdata), .ser_dout(ser_dout), .ser_rdy_n(ser_rdy_n),
  .xfer_irq(xfer_irq), .run(run_w));

// File: tb/nib_serial_slave_test.sv
module nib_serial_slave_test;
  localparam bit LSB = 1'b1;
  localparam int HALF = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] cpu_addr = '0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [3:0] cpu_wdata = '0, cpu_rdata;
  logic ser_clk = 1'b1, ser_din = 1'b0, ser_dout, ser_rdy_n, xfer_irq;

  int total = 0, bad = 0, irq_cnt = 0, cyc = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  nib_serial_slave #(.LSB_FIRST(LSB)) uut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ser_clk(ser_clk),
    .ser_din(ser_din), .ser_dout(ser_dout), .ser_rdy_n(ser_rdy_n), .xfer_irq(xfer_irq));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  bit m_s1 = 1, m_s2 = 1, m_prev = 1, m_d1 = 0, m_d2 = 0;
  bit [7:0] m_sr = 0;
  int m_cnt = 0;
  bit m_run = 0, m_sen = 1, m_irq = 0, m_dout = 0, m_rdy = 1;
  bit [3:0] m_rdata = 0;

  always @(posedge clk) begin
    bit rise, fall, smp, oe, trg, orun;
    if (rst) begin
      m_s1 = 1; m_s2 = 1; m_prev = 1; m_d1 = 0; m_d2 = 0; m_sr = 0; m_cnt = 0;
      m_run = 0; m_sen = 1; m_irq = 0; m_dout = 0; m_rdy = 1; m_rdata = 0;
    end else begin
      orun = m_run;
      rise = !m_prev && m_s2;
      fall = m_prev && !m_s2;
      smp  = m_sen ? rise : fall;
      oe   = m_sen ? fall : rise;
      trg  = cpu_wr && cpu_addr == 2 && cpu_wdata[0] && !orun;
      if (cpu_rd)
        m_rdata = cpu_addr == 0 ? m_sr[3:0] : cpu_addr == 1 ? m_sr[7:4] :
                  cpu_addr == 2 ? {2'b00, m_sen, m_run} : 4'h0;
      if (trg) m_rdy = 0;
      else if ((orun && !m_s2) || ((cpu_wr || cpu_rd) && cpu_addr == 1)) m_rdy = 1;
      m_irq = 0;
      if (trg) begin
        m_run = 1; m_cnt = 0; m_dout = LSB ? m_sr[0] : m_sr[7];
      end else if (orun) begin
        if (smp) begin
          m_sr = LSB ? {m_d2, m_sr[7:1]} : {m_sr[6:0], m_d2};
          m_cnt++;
          if (m_cnt == 8) begin m_run = 0; m_irq = 1; m_cnt = 0; end
        end else if (oe) m_dout = LSB ? m_sr[0] : m_sr[7];
      end else if (cpu_wr) begin
        if (cpu_addr == 0) m_sr[3:0] = cpu_wdata;
        if (cpu_addr == 1) m_sr[7:4] = cpu_wdata;
      end
      if (cpu_wr && cpu_addr == 2 && !orun) m_sen = cpu_wdata[1];
      m_prev = m_s2; m_s2 = m_s1; m_s1 = ser_clk; m_d2 = m_d1; m_d1 = ser_din;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (xfer_irq) irq_cnt++;
    if (!rst && !done_flag) begin
      check("R10 model ser_dout", ser_dout, m_dout);
      check("R4 model ser_rdy_n", ser_rdy_n, m_rdy);
      check("R9 model xfer_irq", xfer_irq, m_irq);
      check("R2 model cpu_rdata", cpu_rdata, m_rdata);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); cpu_addr = 2'(a); cpu_wdata = 4'(d); cpu_wr = 1;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); cpu_addr = 2'(a); cpu_rd = 1;
    @(negedge clk); cpu_rd = 0; v = cpu_rdata;
  endtask

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // master side: sends 'send', returns the byte captured from ser_dout
  task automatic xfer(input bit sen, input bit [7:0] send, input bit chk_rdy,
                      output bit [7:0] tx);
    for (int i = 0; i < 8; i++) begin
      int k = LSB ? i : 7 - i;
      if (sen) begin
        ser_clk = 0; ser_din = send[k];
        waitc(HALF);
        if (i == 0 && chk_rdy) check("R5 ready released by low clock", ser_rdy_n, 1);
        tx[k] = ser_dout;
        ser_clk = 1; waitc(HALF);
      end else begin
        ser_din = send[k]; waitc(2);
        tx[k] = ser_dout;
        ser_clk = 0; waitc(HALF);
        if (i == 0 && chk_rdy) check("R5 ready released by low clock", ser_rdy_n, 1);
        ser_clk = 1; waitc(HALF);
      end
    end
    waitc(4);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, ic;
    bit [7:0] tx;
    waitc(3); rst = 0;
    waitc(1);
    check("R1 rdy_n at reset", ser_rdy_n, 1);
    check("R1 irq at reset", xfer_irq, 0);
    check("R1 dout at reset", ser_dout, 0);
    rd(2, v); check("R1 ctl at reset", v, 4'b0010);

    wr(0, 5); wr(1, 4'hA);
    rd(0, v); check("R2 low half readback", v, 5);
    rd(1, v); check("R2 upper half readback", v, 4'hA);

    // mode 1 transfer
    ic = irq_cnt;
    wr(2, 4'b0011);
    check("R4 ready low after trigger", ser_rdy_n, 0);
    check("R10 first bit presented", ser_dout, LSB ? 1 : 1);
    xfer(1, 8'hC3, 1, tx);
    check("R3 R7 mode1 bits sent", tx, 8'hA5);
    check("R9 one irq pulse", irq_cnt - ic, 1);
    check("R10 dout holds last bit", ser_dout, LSB ? 1 : 1);
    rd(2, v); check("R8 running cleared", v, 4'b0010);
    rd(0, v); check("R3 received low half", v, 3);
    rd(1, v); check("R3 received upper half", v, 4'hC);

    // mode 0 transfer with other bytes
    wr(0, 4'h6); wr(1, 4'h1); wr(2, 0);
    rd(2, v); check("R2 mode bit written", v, 0);
    ic = irq_cnt;
    wr(2, 1);
    rd(2, v); check("R8 running while active", v, 4'b0001);
    xfer(0, 8'h9E, 1, tx);
    check("R7 mode0 bits sent", tx, 8'h16);
    check("R9 mode0 irq pulse", irq_cnt - ic, 1);
    check("R10 mode0 dout holds last bit", ser_dout, LSB ? 0 : 0);
    rd(0, v); check("R7 mode0 low half", v, 4'hE);
    rd(1, v); check("R7 mode0 upper half", v, 4'h9);

    // upper half access releases ready
    wr(2, 4'b0011);
    check("R4 ready low again", ser_rdy_n, 0);
    rd(1, v);
    check("R6 upper read releases ready", ser_rdy_n, 1);
    // writes during run ignored
    wr(0, 4'hF); wr(1, 4'h0); wr(2, 4'b0001);
    rd(2, v); check("R12 mode and run kept", v, 4'b0011);
    ic = irq_cnt;
    xfer(1, 8'h4B, 0, tx);
    check("R12 sent data unchanged by writes", tx, 8'h9E);
    check("R9 irq count", irq_cnt - ic, 1);
    rd(0, v); check("R12 low half from serial", v, 4'hB);
    rd(1, v); check("R12 upper half from serial", v, 4'h4);

    // idle clock toggling ignored
    ic = irq_cnt;
    for (int i = 0; i < 6; i++) begin
      ser_clk = 0; ser_din = i[0]; waitc(HALF); ser_clk = 1; waitc(HALF);
    end
    check("R11 no irq while idle", irq_cnt - ic, 0);
    check("R11 dout unchanged while idle", ser_dout, 1);
    check("R11 rdy stays high", ser_rdy_n, 1);
    rd(0, v); check("R11 low half kept", v, 4'hB);
    rd(1, v); check("R11 upper half kept", v, 4'h4);

    waitc(2);
    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule